// File: doc/BRIEF.md
# PHY Miscellaneous Control Register

This block is one 16-bit management register of an Ethernet PHY. Through a plain register-access port (select, write strobe, write data, read data), software sets repeater mode, the level at which the interrupt pin is active, SQE test inhibit, 10BASE-T loopback, automatic polarity correction disable and receive-clock gating. It also controls two general-purpose pins, each with its own direction bit. A pin set as an output drives its stored data bit. A pin set as an input is read back through a two-flop synchronizer.

The block turns an internal interrupt request into the pin level chosen by the polarity bit. While repeater mode is set, it holds the full-duplex status low and turns the SQE test off. When reset is released, the repeater bit takes the value of a strap input. Serial management framing, the media interface, and the repeater and SQE machinery themselves are outside this block.

Top module: `phy_misc_ctrl`

## Requirements
- R1: During reset and after it, every bit except bit 15 takes a fixed value: bits 10 (loopback), 8 (GPIO1 direction) and 6 (GPIO0 direction) read 1 and all other bits read 0. With both pins low, the read word is 0x0540 plus bit 15.
- R2: Bit 15 (repeater mode) takes the level of `strap_rpt_i` during reset and can be changed later by a write. `rpt_mode_o` shows it.
- R3: Bits 13:12 and 4:1 always read 0, whatever was written to them.
- R4: A write happens only on a clock edge where `reg_sel_i` and `reg_we_i` are both high. It is visible on the read port and outputs from that edge on. At any other edge the register keeps its value.
- R5: Bit 14 sets the interrupt polarity. At 1, `irq_pin_o` equals `irq_req_i`. At 0, `irq_pin_o` is the inverse of `irq_req_i`.
- R6: Bits 8 and 6 are the GPIO1 and GPIO0 directions (1 = input). For an output pin, `gpio_oe_o` is 1 and `gpio_out_o` drives the stored data bit (bit 9 for GPIO1, bit 7 for GPIO0). For an input pin, `gpio_oe_o` is 0.
- R7: For an input pin, the data bit reads the pin level. A change on `gpio_in_i` reaches the read word on the second rising edge after it.
- R8: For an output pin, the data bit reads the stored value, and the level on `gpio_in_i` has no effect on it.
- R9: While bit 15 is 1, `fdx_o` and `sqe_en_o` are both 0. Otherwise `fdx_o` follows `fdx_i`, and `sqe_en_o` is the inverse of bit 11 (SQE inhibit).
- R10: `loopback_o`, `apol_dis_o` and `rxclk_gate_o` show bits 10, 5 and 0.
- R11: `reg_rdata_o` is 0 while `reg_sel_i` is low. While it is high, `reg_rdata_o` is the register word, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| strap_rpt_i | input | 1 | Strap level loaded into repeater mode at reset |
| reg_sel_i | input | 1 | Register address match |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data |
| gpio_in_i | input | 2 | General-purpose pin input levels |
| gpio_oe_o | output | 2 | General-purpose pin output enables |
| gpio_out_o | output | 2 | General-purpose pin output values |
| irq_req_i | input | 1 | Internal interrupt request, active high |
| irq_pin_o | output | 1 | Interrupt pin level |
| fdx_i | input | 1 | Full-duplex status from the link logic |
| fdx_o | output | 1 | Full-duplex status after the repeater override |
| sqe_en_o | output | 1 | SQE test enable |
| rpt_mode_o | output | 1 | Repeater mode |
| loopback_o | output | 1 | 10BASE-T loopback enable |
| apol_dis_o | output | 1 | Automatic polarity correction disable |
| rxclk_gate_o | output | 1 | Receive-clock gating enable |

## Verification
The register is written with all ones and all zeros. These two words separate stored bits from reserved bits and test the repeater override in both states. Pin tests drive one pin and then the other while both are inputs, checking the read after one edge and after two. This measures the synchronizer delay and shows any swap between the two bit positions. The same pins are then held against their stored values while set as outputs, which shows whether the read mux picks the stored bit or the pin. Two resets with opposite strap levels show that bit 15 follows the strap and every other bit stays fixed.

// File: rtl/phy_misc_pkg.sv
package phy_misc_pkg;
  localparam int REG_W       = 16;
  localparam int GPIO_N      = 2;
  localparam int SYNC_STAGES = 2;

  // Bit positions decoded by management software
  localparam int B_RPT  = 15;
  localparam int B_IPOL = 14;
  localparam int B_SQEI = 11;
  localparam int B_LPBK = 10;
  localparam int B_GDIR0 = 6;
  localparam int B_APD  = 5;
  localparam int B_RXG  = 0;
  localparam logic [REG_W-1:0] RSV_MASK = 16'h301E;

  typedef struct packed {
    logic rpt;
    logic ipol;
    logic sqei;
    logic lpbk;
    logic apd;
    logic rxg;
  } ctl_t;

  function automatic int gpio_dir_bit(int idx);
    return B_GDIR0 + 2 * idx;
  endfunction

  function automatic int gpio_dat_bit(int idx);
    return B_GDIR0 + 1 + 2 * idx;
  endfunction

  function automatic ctl_t ctl_reset(logic strap);
    ctl_t v;
    v.rpt  = strap;
    v.ipol = 1'b0;
    v.sqei = 1'b0;
    v.lpbk = 1'b1;
    v.apd  = 1'b0;
    v.rxg  = 1'b0;
    return v;
  endfunction

  function automatic ctl_t ctl_from_word(logic [REG_W-1:0] w);
    ctl_t v;
    v.rpt  = w[B_RPT];
    v.ipol = w[B_IPOL];
    v.sqei = w[B_SQEI];
    v.lpbk = w[B_LPBK];
    v.apd  = w[B_APD];
    v.rxg  = w[B_RXG];
    return v;
  endfunction

  function automatic logic irq_level(logic pol_high, logic req);
    return pol_high ? req : ~req;
  endfunction
endpackage

// File: rtl/phy_misc_sync.sv
module phy_misc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/phy_misc_gpio_cell.sv
module phy_misc_gpio_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_fire_i,
  input  logic wdir_i,
  input  logic wdat_i,
  input  logic pin_i,
  output logic oe_o,
  output logic out_o,
  output logic rd_dir_o,
  output logic rd_dat_o
);
  logic dir_q, dat_q, pin_sync;
  logic [1:0] settle_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      dir_q <= 1'b1;
      dat_q <= 1'b0;
    end else if (wr_fire_i) begin
      dir_q <= wdir_i;
      dat_q <= wdat_i;
    end
  end

  phy_misc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign oe_o     = ~dir_q;
  assign out_o    = dat_q;
  assign rd_dir_o = dir_q;
  assign rd_dat_o = dir_q ? pin_sync : dat_q;

  // cycles since reset, saturating, for the synchronizer check
  always_ff @(posedge clk_i) begin
    if (!rst_ni) settle_q <= 2'd0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  p_dir_apply_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire_i |=> (oe_o == !$past(wdir_i)));

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      p_sync_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (settle_q >= 2'd2) |-> (pin_sync == $past(pin_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/phy_misc_ctl.sv
module phy_misc_ctl
  import phy_misc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic wr_fire_i,
  input  ctl_t wr_val_i,
  output ctl_t ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)        ctl_q <= ctl_reset(strap_i);
    else if (wr_fire_i) ctl_q <= wr_val_i;
  end

  assign ctl_o = ctl_q;

  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire_i |=> (ctl_o == $past(wr_val_i)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_fire_i |=> $stable(ctl_o));
endmodule

// File: rtl/phy_misc_ctrl.sv
module phy_misc_ctrl
  import phy_misc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_rpt_i,
  input  logic              reg_sel_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [GPIO_N-1:0] gpio_in_i,
  output logic [GPIO_N-1:0] gpio_oe_o,
  output logic [GPIO_N-1:0] gpio_out_o,
  input  logic              irq_req_i,
  output logic              irq_pin_o,
  input  logic              fdx_i,
  output logic              fdx_o,
  output logic              sqe_en_o,
  output logic              rpt_mode_o,
  output logic              loopback_o,
  output logic              apol_dis_o,
  output logic              rxclk_gate_o
);
  logic              wr_fire;
  ctl_t              ctl;
  logic [GPIO_N-1:0] dir_rd, dat_rd;
  logic [REG_W-1:0]  word;
  logic              unused_rsv;

  assign wr_fire    = reg_sel_i & reg_we_i;
  assign unused_rsv = ^(reg_wdata_i & RSV_MASK);

  phy_misc_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strap_i  (strap_rpt_i),
    .wr_fire_i(wr_fire),
    .wr_val_i (ctl_from_word(reg_wdata_i)),
    .ctl_o    (ctl)
  );

  generate
    for (genvar g = 0; g < GPIO_N; g++) begin : g_gpio
      phy_misc_gpio_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_fire_i(wr_fire),
        .wdir_i   (reg_wdata_i[gpio_dir_bit(g)]),
        .wdat_i   (reg_wdata_i[gpio_dat_bit(g)]),
        .pin_i    (gpio_in_i[g]),
        .oe_o     (gpio_oe_o[g]),
        .out_o    (gpio_out_o[g]),
        .rd_dir_o (dir_rd[g]),
        .rd_dat_o (dat_rd[g])
      );
    end
  endgenerate

  always_comb begin
    word         = '0;
    word[B_RPT]  = ctl.rpt;
    word[B_IPOL] = ctl.ipol;
    word[B_SQEI] = ctl.sqei;
    word[B_LPBK] = ctl.lpbk;
    word[B_APD]  = ctl.apd;
    word[B_RXG]  = ctl.rxg;
    for (int i = 0; i < GPIO_N; i++) begin
      word[gpio_dir_bit(i)] = dir_rd[i];
      word[gpio_dat_bit(i)] = dat_rd[i];
    end
  end

  assign reg_rdata_o  = reg_sel_i ? word : '0;
  assign irq_pin_o    = irq_level(ctl.ipol, irq_req_i);
  assign fdx_o        = fdx_i & ~ctl.rpt;
  assign sqe_en_o     = ~ctl.sqei & ~ctl.rpt;
  assign rpt_mode_o   = ctl.rpt;
  assign loopback_o   = ctl.lpbk;
  assign apol_dis_o   = ctl.apd;
  assign rxclk_gate_o = ctl.rxg;

  p_rpt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_mode_o |-> (!fdx_o && !sqe_en_o));

  p_irq_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && (reg_rdata_o[B_IPOL] == irq_req_i)) |-> irq_pin_o);

  p_idle_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> (reg_rdata_o == '0));

  p_reserved_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_fire) |-> ((reg_rdata_o & RSV_MASK) == '0));
endmodule

// File: tb/tb_phy_misc_ctrl.sv
module tb_phy_misc_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic        sel = 1'b0, we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  pins = 2'b00, oe, outv;
  logic        irq_req = 1'b0, irq_pin;
  logic        fdx_in = 1'b1, fdx_out, sqe_en, rpt_mode, lpbk, apd, rxg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_misc_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_rpt_i(strap),
    .reg_sel_i(sel), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .gpio_in_i(pins), .gpio_oe_o(oe), .gpio_out_o(outv),
    .irq_req_i(irq_req), .irq_pin_o(irq_pin),
    .fdx_i(fdx_in), .fdx_o(fdx_out), .sqe_en_o(sqe_en), .rpt_mode_o(rpt_mode),
    .loopback_o(lpbk), .apol_dis_o(apd), .rxclk_gate_o(rxg)
  );

  // kind: 0 read word, 1 oe, 2 out, 3 irq pin, 4 fdx, 5 sqe, 6 rpt, 7 {lpbk,apd,rxg}
  function automatic logic [15:0] observe(int kind);
    case (kind)
      0: return rdata;
      1: return {14'd0, oe};
      2: return {14'd0, outv};
      3: return {15'd0, irq_pin};
      4: return {15'd0, fdx_out};
      5: return {15'd0, sqe_en};
      6: return {15'd0, rpt_mode};
      default: return {13'd0, lpbk, apd, rxg};
    endcase
  endfunction

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [15:0] got;
      it = sb_q.pop_front();
      got = observe(it.kind);
      n_run++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind %0d actual %h expected %h", it.req, it.kind, got, it.exp);
      end
    end
  end

  task automatic expect_val(int kind, logic [15:0] exp, string req);
    sb_q.push_back('{kind, exp, req});
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset(logic s);
    @(posedge clk); #1;
    rst_n = 1'b0; strap = s; sel = 1'b0; we = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; sel = 1'b1;
  endtask

  task automatic do_write(logic [15:0] d);
    @(posedge clk); #1;
    sel = 1'b1; we = 1'b1; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  initial begin
    // R1 R2: reset with strap high
    do_reset(1'b1);
    expect_val(0, 16'h8540, "R1");
    expect_val(6, 16'h1, "R2");
    expect_val(1, 16'h0, "R6");
    expect_val(3, 16'h1, "R5");
    expect_val(4, 16'h0, "R9");
    expect_val(5, 16'h0, "R9");
    expect_val(7, 16'h4, "R10");
    settle();
    sel = 1'b0;
    expect_val(0, 16'h0, "R11");
    settle();

    // R3 R4: all-ones write, reserved bits stay 0, inputs read pins
    do_write(16'hFFFF);
    expect_val(0, 16'hCD61, "R3");
    expect_val(7, 16'h7, "R10");
    expect_val(1, 16'h0, "R6");
    irq_req = 1'b0;
    expect_val(3, 16'h0, "R5");
    settle();
    irq_req = 1'b1;
    expect_val(3, 16'h1, "R5");
    settle();

    // R4: strobe without select, and select without strobe
    @(posedge clk); #1; sel = 1'b0; we = 1'b1; wdata = 16'h0000;
    @(posedge clk); #1; sel = 1'b1; we = 1'b0;
    @(posedge clk); #1;
    expect_val(0, 16'hCD61, "R4");
    settle();

    // all-zeros write: repeater off, pins outputs low, active-low irq
    do_write(16'h0000);
    expect_val(0, 16'h0000, "R4");
    expect_val(6, 16'h0, "R2");
    expect_val(1, 16'h3, "R6");
    expect_val(2, 16'h0, "R6");
    expect_val(4, 16'h1, "R9");
    expect_val(5, 16'h1, "R9");
    expect_val(3, 16'h0, "R5");
    settle();

    // R6 R8: outputs driven high while pins held low
    do_write(16'h0280);
    expect_val(2, 16'h3, "R6");
    expect_val(0, 16'h0280, "R8");
    settle();
    do_write(16'h0200);
    pins = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    expect_val(0, 16'h0200, "R8");
    expect_val(2, 16'h2, "R6");
    settle();
    pins = 2'b00;

    // R9: SQE inhibit without repeater
    do_write(16'h0800);
    expect_val(5, 16'h0, "R9");
    expect_val(4, 16'h1, "R9");
    settle();

    // R7: inputs, pins walked one at a time
    do_write(16'h03C0);
    repeat (3) @(posedge clk);
    #1;
    expect_val(0, 16'h0140, "R7");
    expect_val(1, 16'h0, "R6");
    settle();
    pins = 2'b01;
    expect_val(0, 16'h0140, "R7");
    settle();
    expect_val(0, 16'h01C0, "R7");
    settle();
    pins = 2'b10;
    expect_val(0, 16'h01C0, "R7");
    settle();
    expect_val(0, 16'h0340, "R7");
    settle();

    // R1 R2: reset with strap low
    pins = 2'b00;
    do_reset(1'b0);
    repeat (2) @(posedge clk);
    #1;
    expect_val(0, 16'h0540, "R1");
    expect_val(6, 16'h0, "R2");
    expect_val(4, 16'h1, "R9");
    settle();

    settle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule